// File: doc/BRIEF.md
# Fracturable Lane Framer

This block sits on both sides of a bank of codeword engines that share one 32-symbol datapath. A two-bit mode input splits the bus into one channel of 32 lanes, two channels of 16 lanes or four channels of 8 lanes. On the way in it masks each channel's valid bit and symbol lanes, counts beats per channel, marks the first and last beat of every 528-symbol codeword, and zero-fills the lanes of a final beat that reach past the codeword's end. On the way out it takes back each channel's lanes, valid bit, decode failure flag and error count. It re-derives the framing flags and packs the counts into one 12-bit field whose split follows the mode.

Each side has one register stage. The front side hands the engines the gated lanes with start and end flags, the held mode and a restart marker. The engines return the same kind of stream with their status added, and the back side turns it into one output word with a master valid.

Top module: `fxf_lane_framer`

## Requirements
- R1: Mode 0 gives one channel of 32 lanes, mode 1 gives two channels of 16 lanes and mode 2 gives four channels of 8 lanes. Channel c owns lanes c·P to c·P+P−1, with lane 0 in the least significant SYM_W bits. Mode 3 enables no channel.
- R2: A front beat is accepted only when `in_vld` is high. A channel is valid on `core_vld[c]` one cycle later only if `in_vld`, `in_chv[c]` and the mode enable it. The lanes of a channel that is not valid are zero on `core_sym`.
- R3: Channels that the current mode does not enable show zero on every per-channel output bit and error field, on both sides.
- R4: Each channel counts only its own valid beats. It flags start on beat 0 and end on beat B−1, then wraps. B = ceil(528/P): 17, 33 and 66 beats for modes 0, 1 and 2.
- R5: A front beat with `in_sync` high restarts all channel counters, and that beat is beat 0 for every channel valid in it.
- R6: An accepted beat whose mode differs from the held mode restarts all channel counters in the same way as R5.
- R7: On a channel's end beat, lanes at an offset of 528−(B−1)·P or more within the channel are zero. In mode 0 these are lanes 16 to 31. Modes 1 and 2 have no such lanes.
- R8: The back side registers the returned lanes and valid bits one cycle after they arrive. It produces start and end flags from its own counters, which restart on `rs_sync` or on a change of `rs_mode`. `out_vld` is the OR of `out_chv`.
- R9: `out_fail[c]` is `rs_fail[c]` gated by the channel's valid bit. `rs_err` holds 4 bits per channel, channel c at bits 4c+3:4c. In `out_err`, mode 0 places channel 0 in bits 11:0, mode 1 places channel c in bits 6c+5:6c, and mode 2 places channel c in bits 3c+2:3c. Each field saturates at its all-ones value and is zero when its channel is not valid.
- R10: `out_mode` carries the mode that came with the returned beat.
- R11: `core_mode` holds the mode of the last accepted front beat. `core_sync` is high for one cycle after an accepted beat with `in_sync` high.
- R12: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Master valid of the front beat |
| in_mode | input | 2 | Lane split of the front beat |
| in_sync | input | 1 | Restart all codeword counters |
| in_chv | input | 4 | Per-channel valid of the front beat |
| in_sym | input | LANES·SYM_W | Front symbol lanes |
| core_vld | output | 4 | Per-channel valid toward the engines |
| core_sop | output | 4 | Per-channel first beat of a codeword |
| core_eop | output | 4 | Per-channel last beat of a codeword |
| core_sync | output | 1 | Restart marker toward the engines |
| core_mode | output | 2 | Held lane split |
| core_sym | output | LANES·SYM_W | Gated, zero-filled lanes toward the engines |
| rs_chv | input | 4 | Per-channel valid from the engines |
| rs_sync | input | 1 | Restart marker from the engines |
| rs_mode | input | 2 | Lane split from the engines |
| rs_sym | input | LANES·SYM_W | Lanes from the engines |
| rs_fail | input | 4 | Per-channel decode failure |
| rs_err | input | 4·CNT_W | Per-channel error symbol count |
| out_vld | output | 1 | Master valid of the output word |
| out_chv | output | 4 | Per-channel output valid |
| out_sop | output | 4 | Per-channel first beat |
| out_eop | output | 4 | Per-channel last beat |
| out_fail | output | 4 | Per-channel decode failure |
| out_err | output | ERR_W | Packed error counts |
| out_mode | output | 2 | Lane split of the output word |
| out_sym | output | LANES·SYM_W | Output lanes |

## Verification
The bench builds the block with its default parameters: 10-bit symbols, 32 lanes, 528-symbol codewords, 4-bit counts and a 12-bit error field. With these values the final-beat fill in mode 0, the 66-beat frames of mode 2 and count saturation in the narrow 3-bit fields are all reachable in a few hundred cycles. The engine stubs loop the front outputs back into the return inputs. The bench sweeps every mode, gaps in master valid, per-channel stalls, a restart in mid-codeword, mode changes without a restart and every count value from 0 to 15. It checks both sides against an arithmetic model of the framing on every beat.

// File: rtl/fxf_pkg.sv
`timescale 1ns/1ps
package fxf_pkg;

   localparam int FX_NCH = 4;

   typedef enum logic [1:0] {
      FX_X1  = 2'd0,
      FX_X2  = 2'd1,
      FX_X4  = 2'd2,
      FX_OFF = 2'd3
   } fx_mode_e;

   // channel enable mask for a lane split
   function automatic logic [FX_NCH-1:0] fx_act(input logic [1:0] m);
      case (m)
         FX_X1:   return 4'b0001;
         FX_X2:   return 4'b0011;
         FX_X4:   return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/fxf_beat_track.sv
`timescale 1ns/1ps
module fxf_beat_track
   import fxf_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int CW_LEN = 528
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FX_NCH-1:0] adv,
   input  logic              restart,
   input  logic [1:0]        mode,
   output logic [FX_NCH-1:0] sop,
   output logic [FX_NCH-1:0] eop
);
   localparam int BEATS1 = (CW_LEN + LANES - 1) / LANES;
   localparam int BEATS2 = (CW_LEN + LANES/2 - 1) / (LANES/2);
   localparam int BEATS4 = (CW_LEN + LANES/4 - 1) / (LANES/4);
   localparam int CNT_W  = $clog2(BEATS4 + 1);
   localparam logic [CNT_W-1:0] LAST1 = CNT_W'(BEATS1 - 1);
   localparam logic [CNT_W-1:0] LAST2 = CNT_W'(BEATS2 - 1);
   localparam logic [CNT_W-1:0] LAST4 = CNT_W'(BEATS4 - 1);

   if (BEATS1 < 2) begin : g_chk_len
      $error("fxf_beat_track: codeword must span at least two beats");
   end

   logic [CNT_W-1:0] last;

   always_comb begin
      case (mode)
         FX_X2:   last = LAST2;
         FX_X4:   last = LAST4;
         default: last = LAST1;
      endcase
   end

   for (genvar c = 0; c < FX_NCH; c++) begin : g_ch
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] pos;

      assign pos    = restart ? '0 : cnt_q;
      assign sop[c] = adv[c] & (pos == '0);
      assign eop[c] = adv[c] & (pos == last);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (adv[c]) begin
            cnt_q <= (pos == last) ? '0 : pos + CNT_W'(1);
         end else if (restart) begin
            cnt_q <= '0;
         end
      end
   end

   AST_SOP_EOP_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (sop & eop) == '0); // R4

endmodule

// File: rtl/fxf_lane_gate.sv
`timescale 1ns/1ps
module fxf_lane_gate
   import fxf_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int SYM_W  = 10,
   parameter int CW_LEN = 528
) (
   input  logic [1:0]             mode,
   input  logic [FX_NCH-1:0]      ev,
   input  logic [FX_NCH-1:0]      lst,
   input  logic [LANES*SYM_W-1:0] sym_i,
   output logic [LANES*SYM_W-1:0] sym_o
);
   localparam int P2     = LANES / 2;
   localparam int P4     = LANES / 4;
   localparam int BEATS1 = (CW_LEN + LANES - 1) / LANES;
   localparam int BEATS2 = (CW_LEN + P2 - 1) / P2;
   localparam int BEATS4 = (CW_LEN + P4 - 1) / P4;
   localparam int REM1   = CW_LEN - (BEATS1 - 1) * LANES;
   localparam int REM2   = CW_LEN - (BEATS2 - 1) * P2;
   localparam int REM4   = CW_LEN - (BEATS4 - 1) * P4;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int  C2 = l / P2;
      localparam int  C4 = l / P4;
      localparam bit  Z1 = (l >= REM1);
      localparam bit  Z2 = ((l % P2) >= REM2);
      localparam bit  Z4 = ((l % P4) >= REM4);
      logic keep;

      always_comb begin
         case (mode)
            FX_X1:   keep = ev[0]  & ~(lst[0]  & Z1);
            FX_X2:   keep = ev[C2] & ~(lst[C2] & Z2);
            FX_X4:   keep = ev[C4] & ~(lst[C4] & Z4);
            default: keep = 1'b0;
         endcase
      end

      assign sym_o[l*SYM_W +: SYM_W] = keep ? sym_i[l*SYM_W +: SYM_W] : '0;
   end

endmodule

// File: rtl/fxf_status_pack.sv
`timescale 1ns/1ps
module fxf_status_pack
   import fxf_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int ERR_W = 12
) (
   input  logic [1:0]              mode,
   input  logic [FX_NCH-1:0]       vld,
   input  logic [FX_NCH*CNT_W-1:0] err_i,
   output logic [ERR_W-1:0]        err_o
);
   localparam int FW1 = ERR_W;
   localparam int FW2 = ERR_W / 2;
   localparam int FW4 = ERR_W / 4;

   function automatic logic [ERR_W-1:0] clip(input logic [CNT_W-1:0] v,
                                             input int fw);
      logic [ERR_W-1:0] mx;
      logic [ERR_W-1:0] vx;
      mx = (ERR_W'(1) << fw) - ERR_W'(1);
      vx = ERR_W'(v);
      return (vx > mx) ? mx : vx;
   endfunction

   logic [ERR_W-1:0] t;

   always_comb begin
      err_o = '0;
      t     = '0;
      case (mode)
         FX_X1: begin
            t = clip(err_i[0 +: CNT_W], FW1);
            if (vld[0]) err_o = t;
         end
         FX_X2: begin
            for (int c = 0; c < 2; c++) begin
               t = clip(err_i[c*CNT_W +: CNT_W], FW2);
               if (vld[c]) err_o[c*FW2 +: FW2] = t[FW2-1:0];
            end
         end
         FX_X4: begin
            for (int c = 0; c < 4; c++) begin
               t = clip(err_i[c*CNT_W +: CNT_W], FW4);
               if (vld[c]) err_o[c*FW4 +: FW4] = t[FW4-1:0];
            end
         end
         default: err_o = '0;
      endcase
   end

endmodule

// File: rtl/fxf_lane_framer.sv
`timescale 1ns/1ps
module fxf_lane_framer
   import fxf_pkg::*;
#(
   parameter int SYM_W  = 10,
   parameter int LANES  = 32,
   parameter int CW_LEN = 528,
   parameter int CNT_W  = 4,
   parameter int ERR_W  = 12,
   localparam int DW    = LANES * SYM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [1:0]        in_mode,
   input  logic              in_sync,
   input  logic [3:0]        in_chv,
   input  logic [DW-1:0]     in_sym,
   output logic [3:0]        core_vld,
   output logic [3:0]        core_sop,
   output logic [3:0]        core_eop,
   output logic              core_sync,
   output logic [1:0]        core_mode,
   output logic [DW-1:0]     core_sym,
   input  logic [3:0]        rs_chv,
   input  logic              rs_sync,
   input  logic [1:0]        rs_mode,
   input  logic [DW-1:0]     rs_sym,
   input  logic [3:0]        rs_fail,
   input  logic [4*CNT_W-1:0] rs_err,
   output logic              out_vld,
   output logic [3:0]        out_chv,
   output logic [3:0]        out_sop,
   output logic [3:0]        out_eop,
   output logic [3:0]        out_fail,
   output logic [ERR_W-1:0]  out_err,
   output logic [1:0]        out_mode,
   output logic [DW-1:0]     out_sym
);
   if (LANES % FX_NCH != 0) begin : g_chk_lanes
      $error("fxf_lane_framer: LANES must split into four equal channels");
   end
   if (ERR_W % FX_NCH != 0) begin : g_chk_err
      $error("fxf_lane_framer: ERR_W must split into four equal fields");
   end
   if (CNT_W > ERR_W) begin : g_chk_cnt
      $error("fxf_lane_framer: CNT_W wider than ERR_W");
   end

   // ---------------- front side ----------------
   logic [3:0]    ev_f, sop_f, eop_f;
   logic          restart_f;
   logic [DW-1:0] sym_f;

   assign ev_f      = {4{in_vld}} & in_chv & fx_act(in_mode);
   assign restart_f = in_vld & (in_sync | (in_mode != core_mode));

   fxf_beat_track #(.LANES(LANES), .CW_LEN(CW_LEN)) u_trk_f (
      .clk(clk), .rst_n(rst_n), .adv(ev_f), .restart(restart_f),
      .mode(in_mode), .sop(sop_f), .eop(eop_f));

   fxf_lane_gate #(.LANES(LANES), .SYM_W(SYM_W), .CW_LEN(CW_LEN)) u_gate_f (
      .mode(in_mode), .ev(ev_f), .lst(eop_f), .sym_i(in_sym), .sym_o(sym_f));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_vld  <= '0;
         core_sop  <= '0;
         core_eop  <= '0;
         core_sync <= 1'b0;
         core_mode <= 2'd0;
         core_sym  <= '0;
      end else begin
         core_vld  <= ev_f;
         core_sop  <= sop_f;
         core_eop  <= eop_f;
         core_sync <= in_vld & in_sync;
         core_sym  <= sym_f;
         if (in_vld) core_mode <= in_mode;
      end
   end

   // ---------------- back side ----------------
   logic [3:0]       ev_b, sop_b, eop_b;
   logic             restart_b;
   logic [DW-1:0]    sym_b;
   logic [ERR_W-1:0] err_b;

   assign ev_b      = rs_chv & fx_act(rs_mode);
   assign restart_b = rs_sync | (rs_mode != out_mode);

   fxf_beat_track #(.LANES(LANES), .CW_LEN(CW_LEN)) u_trk_b (
      .clk(clk), .rst_n(rst_n), .adv(ev_b), .restart(restart_b),
      .mode(rs_mode), .sop(sop_b), .eop(eop_b));

   fxf_lane_gate #(.LANES(LANES), .SYM_W(SYM_W), .CW_LEN(CW_LEN)) u_gate_b (
      .mode(rs_mode), .ev(ev_b), .lst(eop_b), .sym_i(rs_sym), .sym_o(sym_b));

   fxf_status_pack #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_pack (
      .mode(rs_mode), .vld(ev_b), .err_i(rs_err), .err_o(err_b));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_chv  <= '0;
         out_sop  <= '0;
         out_eop  <= '0;
         out_fail <= '0;
         out_err  <= '0;
         out_mode <= 2'd0;
         out_sym  <= '0;
      end else begin
         out_vld  <= |ev_b;
         out_chv  <= ev_b;
         out_sop  <= sop_b;
         out_eop  <= eop_b;
         out_fail <= ev_b & rs_fail;
         out_err  <= err_b;
         out_mode <= rs_mode;
         out_sym  <= sym_b;
      end
   end

   // ---------------- assertions ----------------
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (core_vld == '0)); // R2
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (core_vld & ~fx_act(core_mode)) == '0); // R3
   AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_sync && in_chv[0] && in_mode != 2'd3) |=> core_sop[0]); // R5
   AST_MASTER_OR: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == (|out_chv)); // R8
   AST_FAIL_IN_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_fail[0]) |-> out_chv[0]); // R9

endmodule

// File: tb/sim_fxf_lane_framer.sv
`timescale 1ns/1ps
module sim_fxf_lane_framer;
   localparam int SYM_W  = 10;
   localparam int LANES  = 32;
   localparam int CW_LEN = 528;
   localparam int CNT_W  = 4;
   localparam int ERR_W  = 12;
   localparam int DW     = LANES * SYM_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             in_vld = 0, in_sync = 0;
   logic [1:0]       in_mode = 0;
   logic [3:0]       in_chv = 0;
   logic [DW-1:0]    in_sym = '0;
   logic [3:0]       core_vld, core_sop, core_eop;
   logic             core_sync;
   logic [1:0]       core_mode;
   logic [DW-1:0]    core_sym;
   logic [3:0]       rs_fail = 0;
   logic [4*CNT_W-1:0] rs_err = '0;
   logic             out_vld;
   logic [3:0]       out_chv, out_sop, out_eop, out_fail;
   logic [ERR_W-1:0] out_err;
   logic [1:0]       out_mode;
   logic [DW-1:0]    out_sym;

   fxf_lane_framer #(.SYM_W(SYM_W), .LANES(LANES), .CW_LEN(CW_LEN),
                     .CNT_W(CNT_W), .ERR_W(ERR_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_mode(in_mode), .in_sync(in_sync), .in_chv(in_chv), .in_sym(in_sym),
      .core_vld(core_vld), .core_sop(core_sop), .core_eop(core_eop),
      .core_sync(core_sync), .core_mode(core_mode), .core_sym(core_sym),
      .rs_chv(core_vld), .rs_sync(core_sync), .rs_mode(core_mode), .rs_sym(core_sym),
      .rs_fail(rs_fail), .rs_err(rs_err),
      .out_vld(out_vld), .out_chv(out_chv), .out_sop(out_sop), .out_eop(out_eop),
      .out_fail(out_fail), .out_err(out_err), .out_mode(out_mode), .out_sym(out_sym));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // model state
   int         cnt [4];
   logic [1:0] mq = 0;
   logic [3:0] e_vld = 0, e_sop = 0, e_eop = 0;
   logic [1:0] e_mode = 0;
   logic [DW-1:0] e_sym = '0;
   int         s = 0;

   function automatic int nch_of(input logic [1:0] m);
      return (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 4 : 0;
   endfunction

   task automatic step(input logic v, input logic [1:0] m, input logic sy,
                       input logic [3:0] cv, input string tag);
      int nch, p, last, rem;
      logic restart;
      logic [3:0] ev, sp, ep, fl;
      logic [DW-1:0] sym, xsym;
      logic [4*CNT_W-1:0] er;
      logic [ERR_W-1:0] xerr;
      // drive (at a falling edge)
      for (int l = 0; l < LANES; l++)
         sym[l*SYM_W +: SYM_W] = SYM_W'(((s*37 + l*11) % 1000) + 1);
      for (int c = 0; c < 4; c++)
         er[c*CNT_W +: CNT_W] = CNT_W'((s + c*5) % 16);
      fl = 4'((s * 7) % 16);
      in_vld = v; in_mode = m; in_sync = sy; in_chv = cv; in_sym = sym;
      rs_fail = fl; rs_err = er;
      // model of this beat on the core side
      nch = nch_of(m);
      p = (nch == 0) ? LANES : LANES / nch;
      last = (CW_LEN + p - 1) / p - 1;
      rem = CW_LEN - last * p;
      restart = v && (sy || m != mq);
      for (int c = 0; c < 4; c++) begin
         int pos;
         ev[c] = v && cv[c] && (c < nch);
         pos = restart ? 0 : cnt[c];
         sp[c] = ev[c] && pos == 0;
         ep[c] = ev[c] && pos == last;
         if (ev[c]) cnt[c] = (pos == last) ? 0 : pos + 1;
         else if (restart) cnt[c] = 0;
      end
      if (v) mq = m;
      xsym = '0;
      for (int l = 0; l < LANES; l++) begin
         int c, off;
         c = l / p; off = l % p;
         if (nch != 0 && ev[c] && !(ep[c] && off >= rem))
            xsym[l*SYM_W +: SYM_W] = sym[l*SYM_W +: SYM_W];
      end
      // expected packed error of the previous core beat
      xerr = '0;
      if (nch_of(e_mode) != 0) begin
         int fw, mx, val;
         fw = ERR_W / nch_of(e_mode);
         mx = (1 << fw) - 1;
         for (int c = 0; c < nch_of(e_mode); c++) begin
            val = int'(er[c*CNT_W +: CNT_W]);
            if (val > mx) val = mx;
            if (e_vld[c]) xerr = xerr | ERR_W'(val << (c*fw));
         end
      end
      @(negedge clk);
      chk("R2 core_vld", DW'(core_vld), DW'(ev));
      chk("R3 unused core_vld", DW'(core_vld & ~4'((1 << nch) - 1)), '0);
      chk("R4 core_sop", DW'(core_sop), DW'(sp));
      chk("R4 core_eop", DW'(core_eop), DW'(ep));
      chk("R1/R7 core_sym", core_sym, xsym);
      chk("R11 core_mode", DW'(core_mode), DW'(mq));
      chk("R11 core_sync", DW'(core_sync), DW'(v & sy));
      if (tag == "R5") chk("R5 sync beat sop", DW'(core_sop), DW'(ev));
      if (tag == "R6") chk("R6 mode change sop", DW'(core_sop), DW'(ev));
      chk("R8 out_vld", DW'(out_vld), DW'(|e_vld));
      chk("R8 out_chv", DW'(out_chv), DW'(e_vld));
      chk("R8 out_sop", DW'(out_sop), DW'(e_sop));
      chk("R8 out_eop", DW'(out_eop), DW'(e_eop));
      chk("R8 out_sym", out_sym, e_sym);
      chk("R9 out_fail", DW'(out_fail), DW'(e_vld & fl));
      chk("R9 out_err", DW'(out_err), DW'(xerr));
      chk("R10 out_mode", DW'(out_mode), DW'(e_mode));
      e_vld = ev; e_sop = sp; e_eop = ep; e_mode = mq; e_sym = xsym;
      s++;
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      for (int c = 0; c < 4; c++) cnt[c] = 0;
      repeat (3) @(negedge clk);
      // R12: outputs in reset
      chk("R12 core_vld", DW'(core_vld), '0);
      chk("R12 core_sym", core_sym, '0);
      chk("R12 core_sync", DW'({core_sync, core_mode, core_sop, core_eop}), '0);
      chk("R12 out_vld", DW'({out_vld, out_chv, out_sop, out_eop, out_fail}), '0);
      chk("R12 out_err", DW'({out_err, out_mode}), '0);
      chk("R12 out_sym", out_sym, '0);
      rst_n = 1'b1;
      // mode 0 with idle gaps: 17-beat frames, fill on last beat
      step(1, 2'd0, 1, 4'hF, "R5");
      for (int i = 0; i < 45; i++)
         step((i % 7) != 3, 2'd0, 0, 4'hF, "");
      // mode 1 entered without sync; channel 1 stalls
      step(1, 2'd1, 0, 4'hF, "R6");
      for (int i = 0; i < 80; i++)
         step(1, 2'd1, 0, ((i % 5) == 2) ? 4'hD : 4'hF, "");
      // mode 2, per-channel stalls, restart in mid-codeword
      step(1, 2'd2, 0, 4'hF, "R6");
      for (int i = 0; i < 150; i++) begin
         logic [3:0] cv;
         cv = 4'hF;
         if (i % 3 == 0) cv[2] = 1'b0;
         if (i % 4 == 1) cv[3] = 1'b0;
         if (i == 40) step(1, 2'd2, 1, cv, "R5");
         else step((i % 11) != 6, 2'd2, 0, cv, "");
      end
      // mode 3: nothing enabled
      for (int i = 0; i < 10; i++) step(1, 2'd3, 0, 4'hF, "");
      // back to mode 0
      step(1, 2'd0, 1, 4'hF, "R5");
      for (int i = 0; i < 20; i++) step(1, 2'd0, 0, 4'h1, "");
      step(0, 2'd0, 0, 4'h0, "");
      step(0, 2'd0, 0, 4'h0, "");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule